// File: doc/BRIEF.md
# DMA Channel Run-State Controller

This block holds the run state of a single DMA channel and exposes it through one 32-bit control/status word. Software writes a command code into an 8-bit command field; after a programmable settling delay the channel takes up the state the command asks for. Software reads the state from a separate 8-bit field and polls it until it shows the value it expects. The delay models the time the data path needs to quiesce.

Two inputs come from the data path. The first says whether descriptors are waiting. The second says whether transfers are still in flight. Two outputs go back to it. One says whether the channel is operational. The other says whether new descriptors may be fetched. A suspend waits for in-flight transfers to drain before it takes effect. A disable passes through a visible stopped state while transfers drain. A reset command drops the channel to disabled at once, whatever is in flight.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After the asynchronous reset, the state field reads disabled (code 0), the command field reads 0, every other bit of the read word is 0, and both `chan_usable` and `fetch_ok` are low.
- R2: The command is taken from write bits 23:16 and read back, as the last accepted code, on read bits 23:16. The state is read on bits 15:8. Bits 31:24 and 7:0 always read 0, and data written to them has no effect.
- R3: With the settle delay S (default 4), a command accepted at clock edge E leaves the state field unchanged through edge E+S-1. The new state appears at edge E+S, unless that command waits for in-flight transfers to drain.
- R4: The enable command (code 1) settles to enabled (state code 1) when `work_pend` is low at the settling edge, and to running (state code 2) when it is high.
- R5: While no command is settling, enabled changes to running one edge after `work_pend` is seen high. Running changes back to enabled one edge after `work_pend` is seen low.
- R6: The suspend command (code 2) settles to suspended (state code 3) only on an edge where `xfer_inflight` is low. Until then the previous state is held.
- R7: The disable command (code 0) settles to disabled (code 0) if nothing is in flight. Otherwise it shows stopped (code 4) until `xfer_inflight` falls, and then disabled one edge later.
- R8: The reset command (code 9) settles to disabled even while `xfer_inflight` is high.
- R9: A write whose command code is not 0, 1, 2 or 9 changes neither the state nor the command field.
- R10: A valid command written while another is still settling replaces it and restarts the full settle delay. The replaced command never takes effect.
- R11: `chan_usable` is high exactly when the state is enabled or running. `fetch_ok` is high only when the state is running and no command is settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data; command in bits 23:16 |
| reg_rdata | output | 32 | Read word: command readback 23:16, state 15:8 |
| work_pend | input | 1 | Descriptors are waiting to be processed |
| xfer_inflight | input | 1 | Transfers are still in flight in the data path |
| chan_usable | output | 1 | State is enabled or running |
| fetch_ok | output | 1 | Data path may fetch new descriptors |

## Verification
The bench looks at the state field on the edge just before the settle delay runs out and again on the edge it runs out. A controller that applied a command early, or one cycle late, fails one of those two checks. Suspend and disable are issued with transfers held in flight for several cycles beyond the delay. An implementation that ignored the drain would show suspended or disabled too soon, and one that skipped the stopped phase would go straight to disabled. A suspend is overwritten by an enable while it is still settling, so a design that did not restart the delay would show suspended at the old deadline. Unknown codes and writes with stray bits set in the other fields are used to catch a decoder that lets them through.

// File: rtl/chctl_pkg.sv
package chctl_pkg;

  localparam int FIELD_W = 8;

  typedef enum logic [FIELD_W-1:0] {
    CMD_DISABLE = 8'd0,
    CMD_ENABLE  = 8'd1,
    CMD_SUSPEND = 8'd2,
    CMD_RESET   = 8'd9
  } cmd_e;

  typedef enum logic [2:0] {
    ST_DISABLED  = 3'd0,
    ST_ENABLED   = 3'd1,
    ST_RUNNING   = 3'd2,
    ST_SUSPENDED = 3'd3,
    ST_STOPPED   = 3'd4
  } state_e;

  function automatic logic cmd_known(input logic [FIELD_W-1:0] code);
    return (code == CMD_DISABLE) || (code == CMD_ENABLE) ||
           (code == CMD_SUSPEND) || (code == CMD_RESET);
  endfunction

endpackage

// File: rtl/chctl_cmd_decode.sv
module chctl_cmd_decode
  import chctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CMD_LSB = 16
) (
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              accept,
  output cmd_e              cmd
);

  logic [FIELD_W-1:0] field;

  always_comb begin
    field  = wdata[CMD_LSB +: FIELD_W];
    accept = wr && cmd_known(field);
    cmd    = cmd_e'(field);
  end

endmodule

// File: rtl/chctl_settle_timer.sv
module chctl_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/chctl_state_core.sv
module chctl_state_core
  import chctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  cmd_e   cmd_in,
  input  logic   expired,
  input  logic   work_pend,
  input  logic   xfer_inflight,
  output state_e state,
  output cmd_e   cmd_last,
  output logic   pending
);

  state_e st_q, st_d;
  cmd_e   cmd_q, cmd_d;
  logic   pend_q, pend_d;

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    pend_d = pend_q;
    if (accept) begin
      cmd_d  = cmd_in;
      pend_d = 1'b1;
    end else if (pend_q && expired) begin
      unique case (cmd_q)
        CMD_RESET: begin
          st_d   = ST_DISABLED;
          pend_d = 1'b0;
        end
        CMD_DISABLE: begin
          if (xfer_inflight) begin
            st_d = ST_STOPPED;
          end else begin
            st_d   = ST_DISABLED;
            pend_d = 1'b0;
          end
        end
        CMD_SUSPEND: begin
          if (!xfer_inflight) begin
            st_d   = ST_SUSPENDED;
            pend_d = 1'b0;
          end
        end
        CMD_ENABLE: begin
          st_d   = work_pend ? ST_RUNNING : ST_ENABLED;
          pend_d = 1'b0;
        end
        default: pend_d = 1'b0;
      endcase
    end else if (!pend_q) begin
      if ((st_q == ST_ENABLED) && work_pend) begin
        st_d = ST_RUNNING;
      end else if ((st_q == ST_RUNNING) && !work_pend) begin
        st_d = ST_ENABLED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_DISABLED;
      cmd_q  <= CMD_DISABLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      pend_q <= pend_d;
    end
  end

  assign state    = st_q;
  assign cmd_last = cmd_q;
  assign pending  = pend_q;

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import chctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CMD_LSB    = 16,
  parameter int ST_LSB     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              work_pend,
  input  logic              xfer_inflight,
  output logic              chan_usable,
  output logic              fetch_ok
);

  logic   accept;
  cmd_e   cmd_dec;
  logic   expired;
  state_e state;
  cmd_e   cmd_last;
  logic   pending;

  chctl_cmd_decode #(
    .DATA_W (DATA_W),
    .CMD_LSB(CMD_LSB)
  ) u_dec (
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .accept(accept),
    .cmd   (cmd_dec)
  );

  chctl_settle_timer #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .run    (pending),
    .expired(expired)
  );

  chctl_state_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .cmd_in       (cmd_dec),
    .expired      (expired),
    .work_pend    (work_pend),
    .xfer_inflight(xfer_inflight),
    .state        (state),
    .cmd_last     (cmd_last),
    .pending      (pending)
  );

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[CMD_LSB +: FIELD_W]  = cmd_last;
    reg_rdata[ST_LSB +: FIELD_W]   = FIELD_W'(state);
  end

  assign chan_usable = (state == ST_ENABLED) || (state == ST_RUNNING);
  assign fetch_ok    = (state == ST_RUNNING) && !pending;

endmodule

// File: rtl/chctl_checker.sv
module chctl_checker #(
  parameter int DATA_W     = 32,
  parameter int CMD_LSB    = 16,
  parameter int ST_LSB     = 8,
  parameter int SETTLE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              work_pend,
  input logic              xfer_inflight,
  input logic              chan_usable,
  input logic              fetch_ok
);

  logic [7:0] st_f;
  logic [7:0] wcmd;
  logic       wknown;

  assign st_f   = reg_rdata[ST_LSB +: 8];
  assign wcmd   = reg_wdata[CMD_LSB +: 8];
  assign wknown = (wcmd == 8'd0) || (wcmd == 8'd1) || (wcmd == 8'd2) || (wcmd == 8'd9);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_f <= 8'd4);

  assert_unknown_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wknown) |=> $stable(reg_rdata[CMD_LSB +: 8]));

  generate
    if (SETTLE_CYC > 1) begin : g_hold
      assert_settle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wknown) |=> $stable(st_f));
    end
  endgenerate

  assert_fetch_running_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ok |-> (st_f == 8'd2));

  assert_usable_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chan_usable == ((st_f == 8'd1) || (st_f == 8'd2)));

  assert_suspend_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_f != 8'd3) && xfer_inflight) |=> (st_f != 8'd3));

  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_f == 8'd4) && xfer_inflight && !reg_wr) |=> (st_f == 8'd4));

endmodule

bind dma_chan_ctrl chctl_checker #(
  .DATA_W    (DATA_W),
  .CMD_LSB   (CMD_LSB),
  .ST_LSB    (ST_LSB),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .work_pend    (work_pend),
  .xfer_inflight(xfer_inflight),
  .chan_usable  (chan_usable),
  .fetch_ok     (fetch_ok)
);

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctrl;

  localparam int S = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        work_pend;
  logic        xfer_inflight;
  logic        chan_usable;
  logic        fetch_ok;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dma_chan_ctrl #(.SETTLE_CYC(S)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .work_pend    (work_pend),
    .xfer_inflight(xfer_inflight),
    .chan_usable  (chan_usable),
    .fetch_ok     (fetch_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic wr_cmd(input logic [7:0] c);
    wr_raw({8'h00, c, 16'h0000});
  endtask

  function automatic logic [7:0] st();
    return reg_rdata[15:8];
  endfunction

  task automatic t_reset();
    chk("R1 read word", reg_rdata, 32'h0);
    chk("R1 usable", chan_usable, 1'b0);
    chk("R1 fetch", fetch_ok, 1'b0);
  endtask

  task automatic t_enable();
    work_pend = 0;
    wr_cmd(8'd1);
    cyc(S - 1);
    chk("R3 held before deadline", st(), 8'd0);
    cyc(1);
    chk("R3 R4 enabled at deadline", st(), 8'd1);
    chk("R11 usable enabled", chan_usable, 1'b1);
    chk("R11 no fetch enabled", fetch_ok, 1'b0);
    chk("R2 cmd readback", reg_rdata[23:16], 8'd1);
  endtask

  task automatic t_run();
    work_pend = 1;
    cyc(1);
    chk("R5 enabled to running", st(), 8'd2);
    chk("R11 fetch running", fetch_ok, 1'b1);
    work_pend = 0;
    cyc(1);
    chk("R5 running to enabled", st(), 8'd1);
  endtask

  task automatic t_ignore();
    wr_raw(32'hC305_5AA5);
    cyc(S + 1);
    chk("R9 state kept", st(), 8'd1);
    chk("R9 cmd kept", reg_rdata[23:16], 8'd1);
    wr_raw(32'hFF01_FFFF);
    cyc(S);
    chk("R2 other bits zero", reg_rdata, 32'h0001_0100);
  endtask

  task automatic t_suspend();
    work_pend = 1;
    cyc(1);
    chk("R5 running before suspend", st(), 8'd2);
    xfer_inflight = 1;
    wr_cmd(8'd2);
    chk("R11 fetch blocked while settling", fetch_ok, 1'b0);
    cyc(S + 3);
    chk("R6 waits for drain", st(), 8'd2);
    xfer_inflight = 0;
    cyc(1);
    chk("R6 suspended after drain", st(), 8'd3);
    chk("R11 usable suspended", chan_usable, 1'b0);
  endtask

  task automatic t_resume();
    wr_cmd(8'd1);
    cyc(S);
    chk("R4 enable with work gives running", st(), 8'd2);
    chk("R11 fetch after resume", fetch_ok, 1'b1);
  endtask

  task automatic t_disable_stop();
    xfer_inflight = 1;
    wr_cmd(8'd0);
    cyc(S);
    chk("R7 stopped while draining", st(), 8'd4);
    chk("R11 usable stopped", chan_usable, 1'b0);
    cyc(3);
    chk("R7 stopped held", st(), 8'd4);
    xfer_inflight = 0;
    cyc(1);
    chk("R7 disabled after drain", st(), 8'd0);
    work_pend = 0;
  endtask

  task automatic t_disable_clean();
    wr_cmd(8'd1);
    cyc(S);
    chk("R4 enabled no work", st(), 8'd1);
    wr_cmd(8'd0);
    cyc(S - 1);
    chk("R3 disable held", st(), 8'd1);
    cyc(1);
    chk("R7 disabled directly", st(), 8'd0);
  endtask

  task automatic t_reset_cmd();
    wr_cmd(8'd1);
    cyc(S);
    xfer_inflight = 1;
    wr_cmd(8'd9);
    cyc(S);
    chk("R8 reset ignores inflight", st(), 8'd0);
    chk("R8 cmd readback", reg_rdata[23:16], 8'd9);
    xfer_inflight = 0;
  endtask

  task automatic t_replace();
    wr_cmd(8'd2);
    cyc(1);
    wr_cmd(8'd1);
    cyc(2);
    chk("R10 replaced suspend not applied", st(), 8'd0);
    cyc(S - 3);
    chk("R10 delay restarted", st(), 8'd0);
    cyc(1);
    chk("R10 replacement applied", st(), 8'd1);
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_wdata = '0; work_pend = 0; xfer_inflight = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_enable();
    t_run();
    t_ignore();
    t_suspend();
    t_resume();
    t_disable_stop();
    t_disable_clean();
    t_reset_cmd();
    t_replace();
    cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule